// File: doc/BRIEF.md
# Suspend Modulation Duty Generator

This block throttles a processor core by toggling an active-low suspend request. It cycles between a released phase, where the core runs, and an asserted phase, where the core idles. Each phase lasts a programmed number of fixed time units of 32 µs. The effective core rate is therefore the full rate scaled by released/(released + asserted). A free-running prescaler turns the system clock into the 32 µs unit tick.

A byte-wide register port holds the two phase counts, a configuration byte whose bit 0 turns modulation on, a power-management enable byte, and two speedup window lengths. Interrupt and video activity inputs can each open a speedup window. While any window is open, the suspend request is held released. When all windows close, cycling restarts with a released phase. A phase with a zero count is skipped. New counts are applied only at the next phase boundary.

Top module: `susmod_gen`

## Requirements
- R1: After reset, `susp_n` is 1. The registers read back as follows: released count (0x94) = 0, asserted count (0x95) = 0, configuration (0x96) = 0, enable byte (0x80) = 0, interrupt window (0x8C) = 4 and video window (0x8D) = 100.
- R2: A write to one of the six mapped addresses is stored in full and can be read back combinationally through `rd_addr`/`rd_data`. A write to any other address changes no register, and reads of such addresses return 0.
- R3: While configuration bit 0 is 0, `susp_n` stays at 1.
- R4: In steady cycling with both counts nonzero, each low pulse of `susp_n` lasts asserted-count × TICK_DIV clocks, and each high pulse lasts released-count × TICK_DIV clocks.
- R5: When modulation is enabled, the first phase is the released phase, so the first fall of `susp_n` comes within released-count unit ticks.
- R6: An asserted count of 0 skips the asserted phase. `susp_n` then stays at 1 while modulation is enabled.
- R7: A released count of 0 with a nonzero asserted count keeps `susp_n` at 0. When both counts are 0, `susp_n` stays at 1.
- R8: A count written during a phase does not change the length of the phase already running. It applies from the next phase of that kind.
- R9: An `irq_evt` pulse while enable bit 3 is set loads the interrupt window timer. The timer counts down once every SPD_UNIT unit ticks. `susp_n` is at 1 from the second clock after the pulse until the window closes. Cycling then resumes with a released phase.
- R10: A `vid_evt` pulse while enable bit 4 is set behaves like R9, using the video window length.
- R11: An activity pulse whose enable bit is 0 has no effect on the running phase.
- R12: Clearing configuration bit 0 during an asserted phase returns `susp_n` to 1 by the second clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Combinational read data |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request to the core |

## Verification
The hardest case to reach from the ports is a count change that lands inside a running phase. A related case is a speedup window that closes and hands control back to the phase sequencer at an arbitrary point of the free-running prescaler. To reach the first case, the stimulus detects the first low sample of an asserted phase and rewrites the asserted count in the next cycle, then measures three consecutive pulse widths. To reach the second, activity pulses are issued right at a phase entry, and the released time that follows is checked against a window bounded by the unknown prescaler phase. Random count pairs drawn from a seeded generator cover the steady-state pulse widths.

// File: rtl/susmod_pkg.sv
package susmod_pkg;

    typedef logic [7:0] byte_t;

    // register addresses (decoded by the write/read port)
    localparam byte_t ADDR_PMEN   = 8'h80;
    localparam byte_t ADDR_IRQ_TC = 8'h8C;
    localparam byte_t ADDR_VID_TC = 8'h8D;
    localparam byte_t ADDR_OFF    = 8'h94;
    localparam byte_t ADDR_ON     = 8'h95;
    localparam byte_t ADDR_CFG    = 8'h96;

    localparam int CFG_EN_BIT = 0;
    localparam int PM_IRQ_BIT = 3;
    localparam int PM_VID_BIT = 4;

    localparam byte_t IRQ_TC_RST = 8'd4;
    localparam byte_t VID_TC_RST = 8'd100;

    localparam int NUM_SPD = 2;
    localparam int SPD_IRQ = 0;
    localparam int SPD_VID = 1;

    typedef enum logic [1:0] {
        PH_DIS  = 2'd0,
        PH_OFF  = 2'd1,
        PH_ON   = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e ph;
        byte_t  rem;
    } phase_sel_t;

    typedef struct packed {
        byte_t off_cnt;
        byte_t on_cnt;
        byte_t cfg;
        byte_t pmen;
        byte_t irq_tc;
        byte_t vid_tc;
    } regs_t;

    // Choose the next phase; zero-length phases are skipped.
    function automatic phase_sel_t pick_phase(logic prefer_on, byte_t off_c, byte_t on_c);
        phase_sel_t r;
        if (prefer_on && on_c != 8'd0)
            r = '{ph: PH_ON, rem: on_c};
        else if (!prefer_on && off_c != 8'd0)
            r = '{ph: PH_OFF, rem: off_c};
        else if (on_c != 8'd0)
            r = '{ph: PH_ON, rem: on_c};
        else if (off_c != 8'd0)
            r = '{ph: PH_OFF, rem: off_c};
        else
            r = '{ph: PH_HOLD, rem: 8'd0};
        return r;
    endfunction

endpackage

// File: rtl/susmod_tick_gen.sv
module susmod_tick_gen #(
    parameter int TICK_DIV = 1600
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (TICK_DIV > 1) begin : g_tick_chk
            // R4
            tick_single_chk: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/susmod_regs.sv
module susmod_regs
    import susmod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wr_addr,
    input  byte_t wr_data,
    input  byte_t rd_addr,
    output byte_t rd_data,
    output regs_t regs_o
);
    regs_t q;
    logic  wr_mapped;

    always_comb begin
        unique case (wr_addr)
            ADDR_OFF, ADDR_ON, ADDR_CFG, ADDR_PMEN, ADDR_IRQ_TC, ADDR_VID_TC: wr_mapped = 1'b1;
            default: wr_mapped = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{off_cnt: 8'd0, on_cnt: 8'd0, cfg: 8'd0, pmen: 8'd0,
                   irq_tc: IRQ_TC_RST, vid_tc: VID_TC_RST};
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_OFF:    q.off_cnt <= wr_data;
                ADDR_ON:     q.on_cnt  <= wr_data;
                ADDR_CFG:    q.cfg     <= wr_data;
                ADDR_PMEN:   q.pmen    <= wr_data;
                ADDR_IRQ_TC: q.irq_tc  <= wr_data;
                ADDR_VID_TC: q.vid_tc  <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_OFF:    rd_data = q.off_cnt;
            ADDR_ON:     rd_data = q.on_cnt;
            ADDR_CFG:    rd_data = q.cfg;
            ADDR_PMEN:   rd_data = q.pmen;
            ADDR_IRQ_TC: rd_data = q.irq_tc;
            ADDR_VID_TC: rd_data = q.vid_tc;
            default:     rd_data = 8'd0;
        endcase
    end

    assign regs_o = q;

    // R2
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_mapped) |=> (q == $past(q)));

endmodule

// File: rtl/susmod_spd_timer.sv
module susmod_spd_timer
    import susmod_pkg::*;
#(
    parameter int SPD_UNIT = 31
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  evt_i,
    input  logic  en_i,
    input  byte_t tc_i,
    output logic  active_o
);
    localparam int SW = (SPD_UNIT > 1) ? $clog2(SPD_UNIT) : 1;
    localparam logic [SW-1:0] SUB_LAST = SW'(SPD_UNIT - 1);

    byte_t         tmr_q;
    logic [SW-1:0] sub_q;
    logic          load;

    assign load = evt_i && en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= 8'd0;
            sub_q <= '0;
        end else if (load) begin
            tmr_q <= tc_i;
            sub_q <= '0;
        end else if (tick_i && tmr_q != 8'd0) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                tmr_q <= tmr_q - 8'd1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign active_o = (tmr_q != 8'd0);

    // R9
    timer_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_q > $past(tmr_q)) |-> $past(load));

endmodule

// File: rtl/susmod_phase_fsm.sv
module susmod_phase_fsm
    import susmod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  run_i,
    input  byte_t off_cnt_i,
    input  byte_t on_cnt_i,
    output logic  susp_n_o
);
    phase_e     st_q;
    byte_t      rem_q;
    phase_sel_t nxt;

    always_comb begin
        nxt = '{ph: st_q, rem: rem_q};
        if (!run_i) begin
            nxt = '{ph: PH_DIS, rem: 8'd0};
        end else begin
            case (st_q)
                PH_DIS:  nxt = pick_phase(1'b0, off_cnt_i, on_cnt_i);
                PH_OFF: if (tick_i) begin
                    if (rem_q > 8'd1) nxt.rem = rem_q - 8'd1;
                    else              nxt = pick_phase(1'b1, off_cnt_i, on_cnt_i);
                end
                PH_ON: if (tick_i) begin
                    if (rem_q > 8'd1) nxt.rem = rem_q - 8'd1;
                    else              nxt = pick_phase(1'b0, off_cnt_i, on_cnt_i);
                end
                PH_HOLD: if (tick_i) nxt = pick_phase(1'b0, off_cnt_i, on_cnt_i);
                default: nxt = '{ph: PH_DIS, rem: 8'd0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_DIS;
            rem_q <= 8'd0;
        end else begin
            st_q  <= nxt.ph;
            rem_q <= nxt.rem;
        end
    end

    assign susp_n_o = (st_q != PH_ON);

    // R12
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> susp_n_o);

    // R6
    on_entry_count_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(susp_n_o) |-> ($past(on_cnt_i) != 8'd0));

    // R8
    phase_change_at_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != $past(st_q)) |-> ($past(tick_i) || !$past(run_i) || $past(st_q) == PH_DIS));

endmodule

// File: rtl/susmod_gen.sv
module susmod_gen
    import susmod_pkg::*;
#(
    parameter int TICK_DIV = 1600,
    parameter int SPD_UNIT = 31
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       irq_evt,
    input  logic       vid_evt,
    output logic       susp_n
);
    regs_t              regs;
    logic               tick;
    logic [NUM_SPD-1:0] spd_evt;
    logic [NUM_SPD-1:0] spd_en;
    logic [NUM_SPD-1:0] spd_act;
    byte_t              spd_tc [NUM_SPD];
    logic               run;

    susmod_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    susmod_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .regs_o(regs)
    );

    assign spd_evt[SPD_IRQ] = irq_evt;
    assign spd_evt[SPD_VID] = vid_evt;
    assign spd_en[SPD_IRQ]  = regs.pmen[PM_IRQ_BIT];
    assign spd_en[SPD_VID]  = regs.pmen[PM_VID_BIT];
    assign spd_tc[SPD_IRQ]  = regs.irq_tc;
    assign spd_tc[SPD_VID]  = regs.vid_tc;

    generate
        for (genvar g = 0; g < NUM_SPD; g++) begin : g_spd
            susmod_spd_timer #(.SPD_UNIT(SPD_UNIT)) u_tmr (
                .clk(clk), .rst(rst), .tick_i(tick), .evt_i(spd_evt[g]),
                .en_i(spd_en[g]), .tc_i(spd_tc[g]), .active_o(spd_act[g])
            );
        end
    endgenerate

    assign run = regs.cfg[CFG_EN_BIT] && !(|spd_act);

    susmod_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .tick_i(tick), .run_i(run),
        .off_cnt_i(regs.off_cnt), .on_cnt_i(regs.on_cnt), .susp_n_o(susp_n)
    );

    // R3
    disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
        !regs.cfg[CFG_EN_BIT] |=> susp_n);

endmodule

// File: tb/susmod_gen_tb.sv
module susmod_gen_tb;
    localparam int D = 4;
    localparam int U = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       irq_evt = 1'b0;
    logic       vid_evt = 1'b0;
    logic       susp_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    susmod_gen #(.TICK_DIV(D), .SPD_UNIT(U)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_evt(irq_evt), .vid_evt(vid_evt),
        .susp_n(susp_n)
    );

    function automatic int plen(int c);
        return c * D;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(logic [7:0] a, int exp, string req);
        rd_addr = a;
        #1;
        chk(rd_data == exp[7:0], req, rd_data, exp);
    endtask

    // count negedges at level lvl, starting from 'start' already counted
    task automatic count_level(logic lvl, int start, int lim, output int n);
        n = start;
        while (n < lim) begin
            @(negedge clk);
            if (susp_n !== lvl) break;
            n++;
        end
    endtask

    task automatic wait_for(logic lvl, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (susp_n === lvl) begin ok = 1'b1; return; end
            @(negedge clk);
        end
    endtask

    task automatic pulse_irq();
        irq_evt = 1'b1; @(negedge clk); irq_evt = 1'b0;
    endtask

    task automatic pulse_vid();
        vid_evt = 1'b1; @(negedge clk); vid_evt = 1'b0;
    endtask

    initial begin
        int n, l, h, a, b, w;
        bit ok;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(susp_n == 1'b1, "R1 susp_n", susp_n, 1);
        rdchk(8'h94, 0, "R1 off");
        rdchk(8'h95, 0, "R1 on");
        rdchk(8'h96, 0, "R1 cfg");
        rdchk(8'h80, 0, "R1 pmen");
        rdchk(8'h8C, 4, "R1 irq window");
        rdchk(8'h8D, 100, "R1 vid window");

        // R2 map and unmapped write
        wr(8'h94, 8'h35);
        rdchk(8'h94, 8'h35, "R2 write off");
        wr(8'h90, 8'hFF);
        rdchk(8'h94, 8'h35, "R2 unmapped write");
        rdchk(8'h95, 0, "R2 unmapped write on");
        rdchk(8'h90, 0, "R2 unmapped read");

        // R3 disabled stays released
        wr(8'h94, 8'd2); wr(8'h95, 8'd3);
        count_level(1'b1, 1, 50, n);
        chk(n >= 50, "R3 disabled high", n, 50);

        // R4/R5 random steady-state widths
        for (int it = 0; it < 5; it++) begin
            a = $urandom_range(1, 6);
            b = $urandom_range(1, 6);
            wr(8'h94, a[7:0]); wr(8'h95, b[7:0]);
            wr(8'h96, 8'h01);
            count_level(1'b1, 1, 2000, n);
            chk(n >= plen(a - 1) && n <= plen(a) + 2, "R5 first released", n, plen(a));
            count_level(1'b0, 1, 2000, l);
            chk(l == plen(b), "R4 low width", l, plen(b));
            count_level(1'b1, 1, 2000, h);
            chk(h == plen(a), "R4 high width", h, plen(a));
            wr(8'h96, 8'h00);
            repeat (2) @(negedge clk);
        end

        // R8 count change mid-phase
        wr(8'h94, 8'd2); wr(8'h95, 8'd2); wr(8'h96, 8'h01);
        wait_for(1'b0, ok);
        wr(8'h95, 8'd5);
        count_level(1'b0, 2, 2000, l);
        chk(l == plen(2), "R8 running phase kept", l, plen(2));
        count_level(1'b1, 1, 2000, h);
        chk(h == plen(2), "R8 released width", h, plen(2));
        count_level(1'b0, 1, 2000, l);
        chk(l == plen(5), "R8 new count applied", l, plen(5));

        // R12 disable during asserted phase
        wait_for(1'b0, ok);
        wr(8'h96, 8'h00);
        @(negedge clk);
        chk(susp_n == 1'b1, "R12 release", susp_n, 1);
        count_level(1'b1, 1, 40, n);
        chk(n >= 40, "R12 stays released", n, 40);

        // R6 asserted count zero
        wr(8'h94, 8'd2); wr(8'h95, 8'd0); wr(8'h96, 8'h01);
        count_level(1'b1, 1, 60, n);
        chk(n >= 60, "R6 on=0 high", n, 60);
        wr(8'h96, 8'h00);

        // R7 released count zero, then both zero
        wr(8'h94, 8'd0); wr(8'h95, 8'd2); wr(8'h96, 8'h01);
        @(negedge clk);
        chk(susp_n == 1'b0, "R7 off=0 low", susp_n, 0);
        count_level(1'b0, 1, 60, n);
        chk(n >= 60, "R7 off=0 stays low", n, 60);
        wr(8'h95, 8'd0);
        repeat (3 * D) @(negedge clk);
        count_level(1'b1, 1, 60, n);
        chk(n >= 60, "R7 both zero high", n, 60);
        wr(8'h96, 8'h00);

        // R11 event with enable bit clear
        wr(8'h94, 8'd3); wr(8'h95, 8'd3); wr(8'h80, 8'h00); wr(8'h96, 8'h01);
        wait_for(1'b0, ok);
        pulse_irq();
        count_level(1'b0, 2, 2000, l);
        chk(l == plen(3), "R11 irq ignored", l, plen(3));

        // R9 interrupt speedup window
        wr(8'h8C, 8'd2); wr(8'h80, 8'h08);
        wait_for(1'b0, ok);
        pulse_irq();
        @(negedge clk);
        chk(susp_n == 1'b1, "R9 forced release", susp_n, 1);
        w = 2 * U;
        count_level(1'b1, 1, 2000, h);
        chk(h >= plen(w + 3 - 2) && h <= plen(w + 3) + 2, "R9 window+released", h, plen(w + 3));
        count_level(1'b0, 1, 2000, l);
        chk(l == plen(3), "R9 resume width", l, plen(3));

        // R11 irq with only the video bit set; R10 video window
        wr(8'h8D, 8'd1); wr(8'h80, 8'h10);
        wait_for(1'b0, ok);
        pulse_irq();
        count_level(1'b0, 2, 2000, l);
        chk(l == plen(3), "R11 irq with video-only enable", l, plen(3));
        wait_for(1'b0, ok);
        pulse_vid();
        @(negedge clk);
        chk(susp_n == 1'b1, "R10 forced release", susp_n, 1);
        w = 1 * U;
        count_level(1'b1, 1, 2000, h);
        chk(h >= plen(w + 3 - 2) && h <= plen(w + 3) + 2, "R10 window+released", h, plen(w + 3));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule